// File: doc/BRIEF.md
# Calendar date counter

This block keeps the calendar date for a clock design. It holds the day of the month, the month and a two-digit year, each as a tens and a units BCD digit. It advances by one day on each cycle where the day-advance enable is high. That enable is normally the one-cycle rollover pulse of a 24-hour time-of-day counter. The day's terminal value follows the current month's length. February's length depends on a leap-year test of the stored year.

All state sits on one clock. The cascade from day to month to year is combinational inside that clock, so a month or year change appears in the same cycle as the day wrap. An active-low clear returns the date to 01/01/00. An active-low load copies a preset date, and a day that does not exist in the loaded month is pulled down to that month's last day. A one-cycle carry marks the year passing from 99 to 00.

No data stream crosses the block's edge, so it has no valid/ready handshake. Every pin is a plain control or status level. The enable is a strobe with no back-pressure: each high cycle is one day, and the block never stalls it.

Top module: `cal_date_counter`

## Requirements
- R1: While `clr_n` is 0 at a clock edge, the date becomes day 01, month 01, year 00 and `year_carry` is 0 after that edge.
- R2: Clear has priority: with `clr_n` = 0 the load and advance inputs have no effect on the date after the edge.
- R3: With `clr_n` = 1 and `load_n` = 0, the preset month and year (two BCD digits each, tens in bits 7:4, units in bits 3:0) are stored, whatever `day_adv` is.
- R4: A loaded preset day above the loaded month's length is stored as that month's last day. Otherwise it is stored unchanged.
- R5: With `clr_n` = 1, `load_n` = 1 and `day_adv` = 0, all six digits hold their value.
- R6: On an advance, a units digit of 9 becomes 0 and the tens digit increments (for example day 09 becomes 10).
- R7: An advance on the month's last day sets the day to 01 and advances the month in the same cycle. Months 1, 3, 5, 7, 8, 10 and 12 have 31 days, and months 4, 6, 9 and 11 have 30. Any other advance leaves month and year unchanged.
- R8: February has 29 days when the year value is divisible by 4 (00, 04, ... 96) and 28 days otherwise.
- R9: An advance on day 31 of month 12 sets the date to 01/01 and increments the year in the same cycle.
- R10: When the year passes from 99 to 00 on an advance, `year_carry` is 1 for exactly the one cycle in which the year first reads 00. It is 0 at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all state |
| clr_n | input | 1 | Synchronous clear to 01/01/00, active low |
| load_n | input | 1 | Synchronous load of the preset date, active low |
| day_adv | input | 1 | One-cycle day-advance strobe |
| preset_day | input | 8 | Preset day, two BCD digits |
| preset_month | input | 8 | Preset month, two BCD digits (01 to 12) |
| preset_year | input | 8 | Preset year, two BCD digits |
| day_tens | output | 4 | Day tens digit |
| day_ones | output | 4 | Day units digit |
| month_tens | output | 4 | Month tens digit |
| month_ones | output | 4 | Month units digit |
| year_tens | output | 4 | Year tens digit |
| year_ones | output | 4 | Year units digit |
| year_carry | output | 1 | One-cycle pulse when the year rolls from 99 to 00 |

## Verification
Several properties are checked on every cycle: the day always lies between 01 and the current month's length, the month stays within 01 to 12, an idle cycle changes nothing, a load takes the preset month and year, a mid-month advance leaves month and year alone, and the year carry appears only on a 99-to-00 step and for one cycle only. Other behaviour only shows up in the bench's scenarios. These include the exact digit values after a wrap, the different lengths of February in leap and common years, the clamping of an impossible loaded day, and the priority of clear over load and of load over advance. The bench checks these against a date model kept in plain integers.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int DIGIT_W = 4;
  localparam int PAIR_W  = 2 * DIGIT_W;
  typedef logic [PAIR_W-1:0] bcd2_t;

  // divisible-by-4 test on a two-digit BCD value
  function automatic logic is_leap(input bcd2_t yr);
    logic [DIGIT_W-1:0] t, u;
    t = yr[PAIR_W-1:DIGIT_W];
    u = yr[DIGIT_W-1:0];
    if (!t[0]) return (u == 4'd0) || (u == 4'd4) || (u == 4'd8);
    else       return (u == 4'd2) || (u == 4'd6);
  endfunction

  function automatic bcd2_t month_last(input bcd2_t mon, input logic leap);
    case (mon)
      8'h02:                      return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/cal_bcd_pair.sv
module cal_bcd_pair #(
  parameter int DIGIT_W = 4,
  parameter logic [2*DIGIT_W-1:0] CLR_VAL   = '0,
  parameter logic [2*DIGIT_W-1:0] FIRST_VAL = '0
) (
  input  logic                 clk,
  input  logic                 clr_n,
  input  logic                 load_n,
  input  logic                 step,
  input  logic [2*DIGIT_W-1:0] load_val,
  input  logic [2*DIGIT_W-1:0] last_val,
  output logic [2*DIGIT_W-1:0] value,
  output logic                 wrap
);
  localparam int PAIR_W = 2 * DIGIT_W;
  localparam logic [DIGIT_W-1:0] NINE = DIGIT_W'(9);

  logic [DIGIT_W-1:0] tens_q, ones_q;
  logic [PAIR_W-1:0]  nxt;

  assign value = {tens_q, ones_q};
  assign wrap  = step && (value >= last_val);

  always_comb begin
    if (wrap)               nxt = FIRST_VAL;
    else if (ones_q == NINE) nxt = {tens_q + DIGIT_W'(1), {DIGIT_W{1'b0}}};
    else                     nxt = {tens_q, ones_q + DIGIT_W'(1)};
  end

  always_ff @(posedge clk) begin
    if (!clr_n)       {tens_q, ones_q} <= CLR_VAL;
    else if (!load_n) {tens_q, ones_q} <= load_val;
    else if (step)    {tens_q, ones_q} <= nxt;
  end
endmodule

// File: rtl/cal_month_limit.sv
module cal_month_limit
  import cal_pkg::*;
(
  input  bcd2_t month,
  input  bcd2_t year,
  output bcd2_t last_day
);
  logic leap;
  assign leap     = is_leap(year);
  assign last_day = month_last(month, leap);
endmodule

// File: rtl/cal_date_counter.sv
module cal_date_counter
  import cal_pkg::*;
(
  input  logic               clk,
  input  logic               clr_n,
  input  logic               load_n,
  input  logic               day_adv,
  input  logic [PAIR_W-1:0]  preset_day,
  input  logic [PAIR_W-1:0]  preset_month,
  input  logic [PAIR_W-1:0]  preset_year,
  output logic [DIGIT_W-1:0] day_tens,
  output logic [DIGIT_W-1:0] day_ones,
  output logic [DIGIT_W-1:0] month_tens,
  output logic [DIGIT_W-1:0] month_ones,
  output logic [DIGIT_W-1:0] year_tens,
  output logic [DIGIT_W-1:0] year_ones,
  output logic               year_carry
);
  bcd2_t day_v, mon_v, yr_v;
  bcd2_t day_last, preset_last, day_load;
  logic  day_wrap, mon_wrap, yr_wrap;
  logic  carry_q;

  // terminal day of the running month and of the preset month
  cal_month_limit u_lim_run (.month(mon_v),        .year(yr_v),        .last_day(day_last));
  cal_month_limit u_lim_pre (.month(preset_month), .year(preset_year), .last_day(preset_last));

  assign day_load = (preset_day > preset_last) ? preset_last : preset_day;

  cal_bcd_pair #(.DIGIT_W(DIGIT_W), .CLR_VAL(8'h01), .FIRST_VAL(8'h01)) u_day (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .step(day_adv),
    .load_val(day_load), .last_val(day_last), .value(day_v), .wrap(day_wrap));

  cal_bcd_pair #(.DIGIT_W(DIGIT_W), .CLR_VAL(8'h01), .FIRST_VAL(8'h01)) u_mon (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .step(day_wrap),
    .load_val(preset_month), .last_val(8'h12), .value(mon_v), .wrap(mon_wrap));

  cal_bcd_pair #(.DIGIT_W(DIGIT_W), .CLR_VAL(8'h00), .FIRST_VAL(8'h00)) u_yr (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .step(mon_wrap),
    .load_val(preset_year), .last_val(8'h99), .value(yr_v), .wrap(yr_wrap));

  always_ff @(posedge clk) begin
    carry_q <= clr_n && load_n && yr_wrap;
  end

  assign {day_tens, day_ones}     = day_v;
  assign {month_tens, month_ones} = mon_v;
  assign {year_tens, year_ones}   = yr_v;
  assign year_carry               = carry_q;
endmodule

// File: rtl/cal_date_checker.sv
module cal_date_checker
  import cal_pkg::*;
(
  input logic               clk,
  input logic               clr_n,
  input logic               load_n,
  input logic               day_adv,
  input logic [PAIR_W-1:0]  preset_month,
  input logic [PAIR_W-1:0]  preset_year,
  input logic [DIGIT_W-1:0] day_tens,
  input logic [DIGIT_W-1:0] day_ones,
  input logic [DIGIT_W-1:0] month_tens,
  input logic [DIGIT_W-1:0] month_ones,
  input logic [DIGIT_W-1:0] year_tens,
  input logic [DIGIT_W-1:0] year_ones,
  input logic               year_carry
);
  bcd2_t d, m, y;
  assign d = {day_tens, day_ones};
  assign m = {month_tens, month_ones};
  assign y = {year_tens, year_ones};

  AST_CLEAR_STATE: assert property (@(posedge clk)
    !clr_n |=> (d == 8'h01) && (m == 8'h01) && (y == 8'h00) && !year_carry); // R1

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!clr_n)
    clr_n && load_n && !day_adv |=> $stable(d) && $stable(m) && $stable(y)); // R5

  AST_LOAD_TAKEN: assert property (@(posedge clk) disable iff (!clr_n)
    clr_n && !load_n |=> (m == $past(preset_month)) && (y == $past(preset_year))); // R3

  AST_DAY_RANGE: assert property (@(posedge clk) disable iff (!clr_n)
    (d >= 8'h01) && (d <= month_last(m, is_leap(y)))); // R7

  AST_MONTH_RANGE: assert property (@(posedge clk) disable iff (!clr_n)
    (m >= 8'h01) && (m <= 8'h12)); // R9

  AST_MIDMONTH_STEP: assert property (@(posedge clk) disable iff (!clr_n)
    clr_n && load_n && day_adv && (d < month_last(m, is_leap(y)))
      |=> $stable(m) && $stable(y)); // R7

  AST_CARRY_SOURCE: assert property (@(posedge clk) disable iff (!clr_n)
    year_carry |-> (y == 8'h00) && ($past(y) == 8'h99)); // R10

  AST_CARRY_PULSE: assert property (@(posedge clk) disable iff (!clr_n)
    year_carry |=> !year_carry); // R10
endmodule

bind cal_date_counter cal_date_checker u_date_chk (
  .clk(clk), .clr_n(clr_n), .load_n(load_n), .day_adv(day_adv),
  .preset_month(preset_month), .preset_year(preset_year),
  .day_tens(day_tens), .day_ones(day_ones),
  .month_tens(month_tens), .month_ones(month_ones),
  .year_tens(year_tens), .year_ones(year_ones),
  .year_carry(year_carry));

// File: tb/test_cal_date_counter.sv
`timescale 1ns/1ps
module test_cal_date_counter;
  logic clk = 1'b0;
  logic clr_n = 1'b0, load_n = 1'b1, day_adv = 1'b0;
  logic [7:0] preset_day = '0, preset_month = 8'h01, preset_year = '0;
  logic [3:0] day_tens, day_ones, month_tens, month_ones, year_tens, year_ones;
  logic year_carry;

  int n_tests = 0, n_fail = 0;
  int ed = 1, em = 1, ey = 0;
  bit ecarry = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  cal_date_counter i_cal_date_counter (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .day_adv(day_adv),
    .preset_day(preset_day), .preset_month(preset_month), .preset_year(preset_year),
    .day_tens(day_tens), .day_ones(day_ones), .month_tens(month_tens),
    .month_ones(month_ones), .year_tens(year_tens), .year_ones(year_ones),
    .year_carry(year_carry));

  function automatic logic [7:0] to_bcd(input int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  function automatic int mlen(input int mo, input int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic check(input string tag);
    logic [24:0] act, exp_v;
    act   = {day_tens, day_ones, month_tens, month_ones, year_tens, year_ones, year_carry};
    exp_v = {to_bcd(ed), to_bcd(em), to_bcd(ey), ecarry};
    n_tests++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s: actual d/m/y/c = %h/%h/%h/%b expected %h/%h/%h/%b", tag,
               act[24:17], act[16:9], act[8:1], act[0],
               exp_v[24:17], exp_v[16:9], exp_v[8:1], exp_v[0]);
    end
  endtask

  // one clock: drive, update model, sample 1 ns after the edge
  task automatic cyc(input bit c, input bit l, input bit a,
                     input int pd, input int pm, input int py, input string tag);
    clr_n = c; load_n = l; day_adv = a;
    preset_day = to_bcd(pd); preset_month = to_bcd(pm); preset_year = to_bcd(py);
    ecarry = 0;
    if (!c) begin ed = 1; em = 1; ey = 0; end
    else if (!l) begin
      em = pm; ey = py; ed = (pd > mlen(pm, py)) ? mlen(pm, py) : pd;
    end else if (a) begin
      if (ed >= mlen(em, ey)) begin
        ed = 1;
        if (em == 12) begin
          em = 1;
          if (ey == 99) begin ey = 0; ecarry = 1; end else ey++;
        end else em++;
      end else ed++;
    end
    @(posedge clk); #1;
    check(tag);
  endtask

  task automatic load(input int d, input int m, input int y);
    cyc(1, 0, 0, d, m, y, "R3");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    cyc(0, 1, 0, 0, 1, 0, "R1");
    cyc(0, 1, 0, 0, 1, 0, "R1");
    cyc(1, 1, 0, 0, 1, 0, "R5");
    // R6 units carry
    load(9, 3, 11);
    cyc(1, 1, 1, 0, 1, 0, "R6");
    cyc(1, 1, 0, 0, 1, 0, "R5");
    // R7 30-day month end
    load(30, 4, 11);
    cyc(1, 1, 1, 0, 1, 0, "R7");
    load(31, 8, 11);
    cyc(1, 1, 1, 0, 1, 0, "R7");
    // R8 February in common and leap years
    load(28, 2, 23);
    cyc(1, 1, 1, 0, 1, 0, "R8");
    load(28, 2, 24);
    cyc(1, 1, 1, 0, 1, 0, "R8");
    cyc(1, 1, 1, 0, 1, 0, "R8");
    load(28, 2, 0);
    cyc(1, 1, 1, 0, 1, 0, "R8");
    load(28, 2, 90);
    cyc(1, 1, 1, 0, 1, 0, "R8");
    // R4 clamping on load
    load(31, 2, 25);
    load(30, 2, 96);
    load(31, 11, 50);
    load(15, 2, 25);
    // R9 and R10 year ends
    load(31, 12, 41);
    cyc(1, 1, 1, 0, 1, 0, "R9");
    load(31, 12, 99);
    cyc(1, 1, 1, 0, 1, 0, "R10");
    cyc(1, 1, 0, 0, 1, 0, "R10");
    cyc(1, 1, 1, 0, 1, 0, "R10");
    // R2 clear beats load and advance, R3 load beats advance
    load(20, 6, 33);
    cyc(0, 0, 1, 5, 7, 44, "R2");
    cyc(1, 0, 1, 5, 7, 44, "R3");
    // long run across a leap cycle
    load(1, 1, 95);
    for (int i = 0; i < 1500; i++) cyc(1, 1, 1, 0, 1, 0, "R7");
    // constrained random mix
    for (int i = 0; i < 6000; i++) begin
      int r = $urandom % 100;
      if (r < 2) cyc(0, $urandom % 2, $urandom % 2, 1, 1, 0, "R1");
      else if (r < 7) cyc(1, 0, $urandom % 2, 1 + $urandom % 31, 1 + $urandom % 12,
                          ($urandom % 4 == 0) ? 99 : $urandom % 100, "R4");
      else if (r < 25) cyc(1, 1, 0, 0, 1, 0, "R5");
      else cyc(1, 1, 1, 0, 1, 0, "R7");
    end
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule